// File: doc/BRIEF.md
# Subchannel Bit-Loading Selector

The block receives one SNR figure per subchannel, as signed Q8.4 decibels, in a stream marked with first and last flags. It decides for each subchannel whether the subchannel is used at all and, if so, which constellation it carries. A subchannel is dropped when its SNR is under the lowest SNR the forward error correction code can work at. The surviving subchannels are then bit-loaded against four rising SNR thresholds. All five decision levels are held in writable registers.

One cycle after each subchannel is presented, the block returns that subchannel's active flag and its 3-bit modulation code. One cycle after the last subchannel of a frame, it also returns two totals for one cycle: the number of active subchannels and B, the sum of coded bits per symbol over the active subchannels. Downstream logic splits transmit power equally among the active subchannels and chooses the code rate from B. That work is done outside this block.

Top module: `subch_bitload`

## Requirements
- R1: A subchannel whose SNR is strictly below the cut-off register (select 0, reset value -2 dB = -32) is reported with sc_active=0 and modulation code 0 (off).
- R2: A used subchannel whose SNR is below the QPSK threshold (select 1) gets code 1 (BPSK, 1 bit).
- R3: SNR at or above the QPSK threshold but below the 16QAM threshold (select 2) gives code 2 (QPSK, 2 bits). SNR at or above the 16QAM threshold but below the 64QAM threshold (select 3) gives code 3 (16QAM, 4 bits).
- R4: SNR at or above the 64QAM threshold but below the 256QAM threshold (select 4) gives code 4 (64QAM, 6 bits). SNR at or above the 256QAM threshold gives code 5 (256QAM, 8 bits).
- R5: An SNR exactly equal to a threshold takes the higher choice. Equal to the cut-off means the subchannel is used.
- R6: After reset the registers hold -32, 24, 106, 208 and 320 in Q8.4, which are -2, 1.5, 6.6, 13 and 20 dB.
- R7: A write with cfg_we=1 loads cfg_data into the register picked by cfg_sel (0..4). The new value applies to subchannels presented in later cycles. A subchannel presented in the same cycle as the write still uses the old value. cfg_sel values 5..7 change nothing.
- R8: sc_valid, sc_active and sc_mod reflect the subchannel presented in the previous cycle. In cycles with no subchannel they are all 0.
- R9: One cycle after a subchannel with snr_last=1, frm_valid is 1. In that cycle frm_count equals the number of active subchannels in the frame, and frm_bits equals the sum of their bits (1/2/4/6/8). In every other cycle all three are 0.
- R10: Totals restart from zero after each frame end. A subchannel presented with snr_first=1 discards any partial totals and opens a new frame.
- R11: While reset is held and in the cycle after it, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select: 0 cut-off, 1 QPSK, 2 16QAM, 3 64QAM, 4 256QAM |
| cfg_data | input | SNR_W | Signed Q8.4 value to write |
| snr_valid | input | 1 | A subchannel SNR is presented |
| snr_first | input | 1 | First subchannel of a frame |
| snr_last | input | 1 | Last subchannel of a frame |
| snr_db | input | SNR_W | Signed Q8.4 SNR in dB |
| sc_valid | output | 1 | Per-subchannel result valid |
| sc_active | output | 1 | Subchannel is used |
| sc_mod | output | 3 | Modulation code 0..5 |
| frm_valid | output | 1 | Frame totals valid, one-cycle pulse |
| frm_count | output | CNT_W | Active subchannel count |
| frm_bits | output | BITS_W | Total coded bits per symbol B |

## Verification
Each per-subchannel result is due at the first rising edge after its input is sampled. The frame totals are due at that same edge for the subchannel flagged last. A register write affects classification one edge after it is sampled. The bench drives a single input cycle, waits for the next rising edge, and samples 1 ns later. At that point it compares every output against a behavioural model that has been advanced by exactly that one cycle. Idle cycles, reset cycles and write cycles are compared the same way, so a result that comes out early or late is caught.

// File: rtl/sbl_pkg.sv
package sbl_pkg;

    localparam int NUM_THR = 5;

    typedef enum logic [2:0] {
        MOD_OFF    = 3'd0,
        MOD_BPSK   = 3'd1,
        MOD_QPSK   = 3'd2,
        MOD_QAM16  = 3'd3,
        MOD_QAM64  = 3'd4,
        MOD_QAM256 = 3'd5
    } mod_e;

    // Register selects; ordering is the threshold ladder used by the classifier.
    typedef enum logic [2:0] {
        SEL_CUTOFF = 3'd0,
        SEL_QPSK   = 3'd1,
        SEL_QAM16  = 3'd2,
        SEL_QAM64  = 3'd3,
        SEL_QAM256 = 3'd4
    } cfg_sel_e;

    typedef struct packed {
        logic active;
        mod_e md;
    } sc_res_t;

    function automatic logic [3:0] bits_of(input mod_e m);
        case (m)
            MOD_BPSK:   return 4'd1;
            MOD_QPSK:   return 4'd2;
            MOD_QAM16:  return 4'd4;
            MOD_QAM64:  return 4'd6;
            MOD_QAM256: return 4'd8;
            default:    return 4'd0;
        endcase
    endfunction

    // Tenths of a dB to fixed point, rounded half away from zero.
    function automatic int tenths_to_q(input int tenths, input int frac);
        int num;
        num = tenths * (2 ** frac) * 2;
        if (num >= 0) return (num + 10) / 20;
        else          return (num - 10) / 20;
    endfunction

    localparam int RST_TENTHS [NUM_THR] = '{-20, 15, 66, 130, 200};

endpackage

// File: rtl/sbl_thr_regs.sv
module sbl_thr_regs
    import sbl_pkg::*;
#(
    parameter int SNR_W  = 12,
    parameter int FRAC_W = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    cfg_we,
    input  logic [2:0]              cfg_sel,
    input  logic signed [SNR_W-1:0] cfg_data,
    output logic signed [SNR_W-1:0] thr [NUM_THR]
);

    for (genvar i = 0; i < NUM_THR; i++) begin : g_thr
        localparam logic signed [SNR_W-1:0] RST_VAL =
            SNR_W'(tenths_to_q(RST_TENTHS[i], FRAC_W));
        always_ff @(posedge clk) begin
            if (rst)
                thr[i] <= RST_VAL;
            else if (cfg_we && cfg_sel == 3'(i))
                thr[i] <= cfg_data;
        end
    end

endmodule

// File: rtl/sbl_classify.sv
module sbl_classify
    import sbl_pkg::*;
#(
    parameter int SNR_W = 12
) (
    input  logic signed [SNR_W-1:0] snr,
    input  logic signed [SNR_W-1:0] thr [NUM_THR],
    output sc_res_t                 res
);

    always_comb begin
        res.active = (snr >= thr[SEL_CUTOFF]);
        if (!res.active)
            res.md = MOD_OFF;
        else if (snr >= thr[SEL_QAM256])
            res.md = MOD_QAM256;
        else if (snr >= thr[SEL_QAM64])
            res.md = MOD_QAM64;
        else if (snr >= thr[SEL_QAM16])
            res.md = MOD_QAM16;
        else if (snr >= thr[SEL_QPSK])
            res.md = MOD_QPSK;
        else
            res.md = MOD_BPSK;
    end

endmodule

// File: rtl/sbl_frame_accum.sv
module sbl_frame_accum
    import sbl_pkg::*;
#(
    parameter int CNT_W  = 9,
    parameter int BITS_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              in_first,
    input  logic              in_last,
    input  sc_res_t           res,
    output logic              frm_valid,
    output logic [CNT_W-1:0]  frm_count,
    output logic [BITS_W-1:0] frm_bits
);

    logic [CNT_W-1:0]  acc_cnt, nxt_cnt;
    logic [BITS_W-1:0] acc_bits, nxt_bits;

    always_comb begin
        nxt_cnt  = (in_first ? '0 : acc_cnt) + CNT_W'(res.active);
        nxt_bits = (in_first ? '0 : acc_bits) + BITS_W'(bits_of(res.md));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_cnt   <= '0;
            acc_bits  <= '0;
            frm_valid <= 1'b0;
            frm_count <= '0;
            frm_bits  <= '0;
        end else begin
            frm_valid <= 1'b0;
            frm_count <= '0;
            frm_bits  <= '0;
            if (in_valid) begin
                if (in_last) begin
                    frm_valid <= 1'b1;
                    frm_count <= nxt_cnt;
                    frm_bits  <= nxt_bits;
                    acc_cnt   <= '0;
                    acc_bits  <= '0;
                end else begin
                    acc_cnt   <= nxt_cnt;
                    acc_bits  <= nxt_bits;
                end
            end
        end
    end

endmodule

// File: rtl/subch_bitload.sv
module subch_bitload
    import sbl_pkg::*;
#(
    parameter int SNR_W   = 12,
    parameter int FRAC_W  = 4,
    parameter int MAX_SUB = 256,
    localparam int CNT_W  = $clog2(MAX_SUB + 1),
    localparam int BITS_W = $clog2(MAX_SUB * 8 + 1)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    cfg_we,
    input  logic [2:0]              cfg_sel,
    input  logic signed [SNR_W-1:0] cfg_data,
    input  logic                    snr_valid,
    input  logic                    snr_first,
    input  logic                    snr_last,
    input  logic signed [SNR_W-1:0] snr_db,
    output logic                    sc_valid,
    output logic                    sc_active,
    output logic [2:0]              sc_mod,
    output logic                    frm_valid,
    output logic [CNT_W-1:0]        frm_count,
    output logic [BITS_W-1:0]       frm_bits
);

    logic signed [SNR_W-1:0] thr [NUM_THR];
    sc_res_t                 res;

    sbl_thr_regs #(.SNR_W(SNR_W), .FRAC_W(FRAC_W)) u_regs (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_data(cfg_data), .thr(thr)
    );

    sbl_classify #(.SNR_W(SNR_W)) u_cls (
        .snr(snr_db), .thr(thr), .res(res)
    );

    sbl_frame_accum #(.CNT_W(CNT_W), .BITS_W(BITS_W)) u_acc (
        .clk(clk), .rst(rst), .in_valid(snr_valid), .in_first(snr_first),
        .in_last(snr_last), .res(res), .frm_valid(frm_valid),
        .frm_count(frm_count), .frm_bits(frm_bits)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sc_valid  <= 1'b0;
            sc_active <= 1'b0;
            sc_mod    <= MOD_OFF;
        end else begin
            sc_valid  <= snr_valid;
            sc_active <= snr_valid && res.active;
            sc_mod    <= snr_valid ? res.md : MOD_OFF;
        end
    end

endmodule

// File: rtl/sbl_checker.sv
module sbl_checker #(
    parameter int CNT_W  = 9,
    parameter int BITS_W = 12
) (
    input logic              clk,
    input logic              rst,
    input logic              snr_valid,
    input logic              snr_last,
    input logic              sc_valid,
    input logic              sc_active,
    input logic [2:0]        sc_mod,
    input logic              frm_valid,
    input logic [CNT_W-1:0]  frm_count,
    input logic [BITS_W-1:0] frm_bits
);

    // R8: a result follows every presented subchannel by one cycle
    a_r8_result_follows: assert property (@(posedge clk) disable iff (rst)
        snr_valid |=> sc_valid);

    // R8: no result without a subchannel
    a_r8_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !snr_valid |=> !sc_valid);

    // R8: idle outputs are cleared
    a_r8_idle_clear: assert property (@(posedge clk) disable iff (rst)
        !sc_valid |-> (!sc_active && sc_mod == 3'd0));

    // R1: an unused subchannel carries the off code
    a_r1_off_code: assert property (@(posedge clk) disable iff (rst)
        (sc_valid && !sc_active) |-> sc_mod == 3'd0);

    // R9: the frame totals pulse after the last subchannel
    a_r9_frame_pulse: assert property (@(posedge clk) disable iff (rst)
        (snr_valid && snr_last) |=> frm_valid);

    // R9: totals read zero outside the pulse
    a_r9_zero_outside: assert property (@(posedge clk) disable iff (rst)
        !frm_valid |-> (frm_count == '0 && frm_bits == '0));

    // R9: B lies between 1 and 8 bits per active subchannel
    a_r9_bits_range: assert property (@(posedge clk) disable iff (rst)
        frm_valid |-> (int'(frm_bits) >= int'(frm_count)
                       && int'(frm_bits) <= 8 * int'(frm_count)));

endmodule

bind subch_bitload sbl_checker #(.CNT_W(CNT_W), .BITS_W(BITS_W)) u_chk (.*);

// File: tb/subch_bitload_tb.sv
module subch_bitload_tb;

    localparam int SNR_W = 12;
    localparam int CNT_W = 9;
    localparam int BITS_W = 12;

    logic clk = 1'b0;
    logic rst;
    logic cfg_we;
    logic [2:0] cfg_sel;
    logic signed [SNR_W-1:0] cfg_data;
    logic snr_valid, snr_first, snr_last;
    logic signed [SNR_W-1:0] snr_db;
    logic sc_valid, sc_active;
    logic [2:0] sc_mod;
    logic frm_valid;
    logic [CNT_W-1:0] frm_count;
    logic [BITS_W-1:0] frm_bits;

    always #2 clk = ~clk;

    subch_bitload u_dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_data(cfg_data), .snr_valid(snr_valid), .snr_first(snr_first),
        .snr_last(snr_last), .snr_db(snr_db), .sc_valid(sc_valid),
        .sc_active(sc_active), .sc_mod(sc_mod), .frm_valid(frm_valid),
        .frm_count(frm_count), .frm_bits(frm_bits)
    );

    int checks = 0;
    int fails = 0;

    // Behavioural model state
    int thr [5] = '{-32, 24, 106, 208, 320};
    int acc_cnt = 0;
    int acc_bits = 0;

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic int model_mod(int s);
        if (s < thr[0]) return 0;
        if (s >= thr[4]) return 5;
        if (s >= thr[3]) return 4;
        if (s >= thr[2]) return 3;
        if (s >= thr[1]) return 2;
        return 1;
    endfunction

    function automatic int bits_for(int m);
        case (m)
            1: return 1;
            2: return 2;
            3: return 4;
            4: return 6;
            5: return 8;
            default: return 0;
        endcase
    endfunction

    // One input cycle, then compare every output one edge later.
    task automatic step(bit v, bit f, bit l, int s, string tag,
                        bit we = 1'b0, int sel = 0, int d = 0);
        int e_mod, e_fv, e_cnt, e_bits, base_c, base_b;
        snr_valid = v; snr_first = f; snr_last = l; snr_db = SNR_W'(s);
        cfg_we = we; cfg_sel = 3'(sel); cfg_data = SNR_W'(d);
        e_mod = v ? model_mod(s) : 0;
        e_fv = 0; e_cnt = 0; e_bits = 0;
        if (v) begin
            base_c = f ? 0 : acc_cnt;
            base_b = f ? 0 : acc_bits;
            base_c += (e_mod != 0) ? 1 : 0;
            base_b += bits_for(e_mod);
            if (l) begin
                e_fv = 1; e_cnt = base_c; e_bits = base_b;
                acc_cnt = 0; acc_bits = 0;
            end else begin
                acc_cnt = base_c; acc_bits = base_b;
            end
        end
        if (we && sel < 5) thr[sel] = d;
        @(posedge clk);
        #1;
        chk("R8", "sc_valid", int'(sc_valid), int'(v));
        chk(tag, "sc_active", int'(sc_active), (e_mod != 0) ? 1 : 0);
        chk(tag, "sc_mod", int'(sc_mod), e_mod);
        chk(tag, "frm_valid", int'(frm_valid), e_fv);
        chk(tag, "frm_count", int'(frm_count), e_cnt);
        chk(tag, "frm_bits", int'(frm_bits), e_bits);
    endtask

    initial begin
        #(200000 * 4);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        rst = 1'b1;
        cfg_we = 1'b0; cfg_sel = '0; cfg_data = '0;
        snr_valid = 1'b0; snr_first = 1'b0; snr_last = 1'b0; snr_db = '0;
        repeat (3) @(posedge clk);
        #1;
        // R11: outputs cleared while reset is held
        chk("R11", "sc_valid", int'(sc_valid), 0);
        chk("R11", "sc_mod", int'(sc_mod), 0);
        chk("R11", "frm_valid", int'(frm_valid), 0);
        chk("R11", "frm_bits", int'(frm_bits), 0);
        rst = 1'b0;
        step(0, 0, 0, 0, "R11");

        // Default thresholds, every band and each reset level (R6)
        step(1, 1, 0, -33, "R1");
        step(1, 0, 0, -2048, "R1");
        step(1, 0, 0, -32, "R6");
        step(1, 0, 0, 23, "R2");
        step(1, 0, 0, 24, "R6");
        step(1, 0, 0, 105, "R3");
        step(0, 0, 0, 0, "R8");
        step(1, 0, 0, 106, "R6");
        step(1, 0, 0, 150, "R3");
        step(1, 0, 0, 207, "R3");
        step(1, 0, 0, 208, "R6");
        step(1, 0, 0, 319, "R4");
        step(1, 0, 0, 320, "R6");
        step(1, 0, 0, 2047, "R4");
        step(1, 0, 1, 0, "R9");
        step(0, 0, 0, 0, "R9");

        // Back-to-back frame: totals start from zero (R10)
        step(1, 0, 0, 300, "R10");
        step(1, 0, 1, 50, "R10");

        // Restart with first mid-frame (R10)
        step(1, 1, 0, 400, "R10");
        step(1, 0, 0, 400, "R10");
        step(1, 1, 0, 24, "R10");
        step(1, 0, 1, 10, "R10");

        // Register writes (R7), unmapped select ignored
        step(0, 0, 0, 0, "R7", 1'b1, 0, 0);
        step(0, 0, 0, 0, "R7", 1'b1, 6, 100);
        step(0, 0, 0, 0, "R7", 1'b1, 1, 40);
        step(1, 1, 0, -1, "R7");
        step(1, 0, 0, 0, "R5");
        step(1, 0, 0, 39, "R7");
        step(1, 0, 0, 40, "R5");
        step(1, 0, 0, 100, "R7");
        step(1, 0, 0, 106, "R7");
        // write in the same cycle as a subchannel: old value still applies
        step(1, 0, 0, 40, "R7", 1'b1, 1, 50);
        step(1, 0, 0, 45, "R7");
        step(1, 0, 1, 50, "R5");

        // Single-subchannel frame and an all-off frame (R9)
        step(1, 1, 1, 500, "R9");
        step(1, 1, 0, -5, "R1");
        step(1, 0, 1, -100, "R9");
        step(0, 0, 0, 0, "R9");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule